// File: doc/BRIEF.md
# Flash Rewrite Control Registers with Erase-Suspend Logic

This block provides two byte-wide control registers for a flash rewrite controller, reached over a simple single-cycle register write port with a combinational read port. The mode register holds a select bit that picks one of two erase-while-executing behaviours: a software-suspend mode (0) in which code running during an erase raises and drops the suspend request itself, and an interrupt-suspend mode (1) in which taking a maskable interrupt during an erase raises the request automatically.

The suspend register holds the erase-suspend enable, the suspend request (0 means erase resumes, 1 means suspend is requested) and a read-only flag that mirrors a read-status-ready input. The mode bit and the suspend enable are guarded: each is set only by a write of 0 immediately followed by a write of 1, with no other register write and no interrupt in between. The mode bit additionally requires the master rewrite-enable input, and dropping that input clears it. The suspend request is forced to 0 whenever suspend is not enabled or no erase is running.

Top module: `flash_ctl_regs`

## Requirements
- R1: During and directly after reset, the mode register (address 0) reads 0x00, the suspend register (address 1) reads 0x40, and mode_sel, susp_en and susp_req are 0.
- R2: The mode bit (address 0, bit 0) becomes 1 only when a write of 0 to it is followed by the very next register write putting 1 there, with rewrite_en high at that second write; a lone write of 1 leaves it unchanged.
- R3: While rewrite_en is low the mode bit is 0 from the next clock on and cannot be set.
- R4: The suspend enable (address 1, bit 0) becomes 1 only through the same 0-then-1 pair of consecutive writes to address 1; a lone write of 1 leaves it unchanged.
- R5: A register write to any other address, or an irq_taken pulse, between the 0 write and the 1 write breaks the pair so the 1 write has no effect.
- R6: Writing 0 to either guarded bit clears it on the next clock.
- R7: The suspend request (address 1, bit 1) is 0 on the clock after any cycle in which susp_en and erase_busy are not both 1.
- R8: In mode 0 with suspend enabled and an erase running, a write to address 1 loads bit 1 into the suspend request; irq_taken does not change it.
- R9: In mode 1 with suspend enabled and an erase running, an irq_taken pulse sets the suspend request on the next clock; a written 1 has no effect and a written 0 clears it.
- R10: Bit 6 of address 1 shows status_ready as sampled at the previous clock (1 during reset), and writes to it have no effect.
- R11: All other bits of both registers, and every address other than 0 and 1, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 4 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| rewrite_en | input | 1 | Master CPU-rewrite enable |
| erase_busy | input | 1 | An erase is in progress |
| irq_taken | input | 1 | Single-cycle pulse when a maskable interrupt is taken |
| status_ready | input | 1 | Status may be read from the array |
| mode_sel | output | 1 | 0 software-suspend mode, 1 interrupt-suspend mode |
| susp_en | output | 1 | Erase-suspend enable |
| susp_req | output | 1 | Suspend request, 1 requests suspend |

## Verification
The assertions take for granted that irq_taken, rewrite_en, erase_busy and status_ready are synchronous to clk and that at most one register write happens per cycle. They also assume nothing outside the block changes the guarded bits, so a rise of either guarded bit can be traced to a write in the previous cycle. The stimulus drives every input on the falling edge, pulses irq_taken and wr_en for exactly one cycle and never overlaps them, and resets between sweep points so each unlock trial starts from a known disarmed state.

// File: rtl/flc_pkg.sv
package flc_pkg;

    localparam int DATA_W = 8;

    // Bit positions inside the two registers (guard and suspend decode use them)
    localparam int MODE_BIT = 0;
    localparam int SEN_BIT  = 0;
    localparam int SREQ_BIT = 1;
    localparam int STAT_BIT = 6;

    localparam logic [DATA_W-1:0] SUSP_RST = 8'h40;

    localparam int NUM_GUARD = 2;
    localparam int G_MODE    = 0;
    localparam int G_SEN     = 1;

    typedef enum logic {
        MODE_SW  = 1'b0,
        MODE_IRQ = 1'b1
    } susp_mode_e;

    typedef struct packed {
        logic              hit_mode;
        logic              hit_susp;
        logic              any;
        logic [DATA_W-1:0] data;
    } bus_op_t;

    function automatic bus_op_t decode_op(
        input logic        wr,
        input logic [31:0] a,
        input logic [31:0] mode_a,
        input logic [31:0] susp_a,
        input logic [DATA_W-1:0] d
    );
        bus_op_t op;
        op.any      = wr;
        op.hit_mode = wr && (a == mode_a);
        op.hit_susp = wr && (a == susp_a);
        op.data     = d;
        return op;
    endfunction

endpackage

// File: rtl/flc_unlock_bit.sv
module flc_unlock_bit (
    input  logic clk,
    input  logic rst,
    input  logic wr_this,
    input  logic wr_any,
    input  logic bit_in,
    input  logic brk,
    input  logic allow,
    input  logic force_clr,
    output logic q
);
    logic armed;
    logic armed_ok;

    assign armed_ok = armed && !brk;

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= 1'b0;
            armed <= 1'b0;
        end else if (force_clr) begin
            q     <= 1'b0;
            armed <= 1'b0;
        end else if (wr_this) begin
            if (!bit_in) begin
                q     <= 1'b0;
                armed <= !brk;
            end else begin
                if (armed_ok && allow) begin
                    q <= 1'b1;
                end
                armed <= 1'b0;
            end
        end else if (wr_any || brk) begin
            armed <= 1'b0;
        end
    end
endmodule

// File: rtl/flc_suspend_ctl.sv
module flc_suspend_ctl
    import flc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  susp_mode_e mode,
    input  logic       en,
    input  logic       busy,
    input  logic       irq,
    input  logic       wr,
    input  logic       bit_in,
    output logic       req
);
    logic window;
    logic nxt;

    assign window = en && busy;

    always_comb begin
        nxt = req;
        if (!window) begin
            nxt = 1'b0;
        end else begin
            unique case (mode)
                MODE_SW: begin
                    if (wr) nxt = bit_in;
                end
                MODE_IRQ: begin
                    if (irq)                nxt = 1'b1;
                    else if (wr && !bit_in) nxt = 1'b0;
                end
                default: nxt = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= nxt;
    end
endmodule

// File: rtl/flc_read_mux.sv
module flc_read_mux
    import flc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int MODE_ADDR = 0,
    parameter int SUSP_ADDR = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mode_q,
    input  logic              sen_q,
    input  logic              sreq_q,
    input  logic              stat_q,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mode_word;
    logic [DATA_W-1:0] susp_word;

    always_comb begin
        mode_word           = '0;
        mode_word[MODE_BIT] = mode_q;
        susp_word           = '0;
        susp_word[SEN_BIT]  = sen_q;
        susp_word[SREQ_BIT] = sreq_q;
        susp_word[STAT_BIT] = stat_q;
        if (32'(addr) == MODE_ADDR)      rdata = mode_word;
        else if (32'(addr) == SUSP_ADDR) rdata = susp_word;
        else                             rdata = '0;
    end
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
    import flc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int MODE_ADDR = 0,
    parameter int SUSP_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              rewrite_en,
    input  logic              erase_busy,
    input  logic              irq_taken,
    input  logic              status_ready,
    output logic              mode_sel,
    output logic              susp_en,
    output logic              susp_req
);
    bus_op_t op;
    logic    stat_q;

    logic [NUM_GUARD-1:0] g_wr;
    logic [NUM_GUARD-1:0] g_bit;
    logic [NUM_GUARD-1:0] g_allow;
    logic [NUM_GUARD-1:0] g_clr;
    logic [NUM_GUARD-1:0] g_q;

    assign op = decode_op(wr_en, 32'(addr), 32'(MODE_ADDR), 32'(SUSP_ADDR), wdata);

    always_comb begin
        g_wr[G_MODE]    = op.hit_mode;
        g_bit[G_MODE]   = op.data[MODE_BIT];
        g_allow[G_MODE] = rewrite_en;
        g_clr[G_MODE]   = !rewrite_en;
        g_wr[G_SEN]     = op.hit_susp;
        g_bit[G_SEN]    = op.data[SEN_BIT];
        g_allow[G_SEN]  = 1'b1;
        g_clr[G_SEN]    = 1'b0;
    end

    for (genvar i = 0; i < NUM_GUARD; i++) begin : g_guard
        flc_unlock_bit u_bit (
            .clk      (clk),
            .rst      (rst),
            .wr_this  (g_wr[i]),
            .wr_any   (op.any),
            .bit_in   (g_bit[i]),
            .brk      (irq_taken),
            .allow    (g_allow[i]),
            .force_clr(g_clr[i]),
            .q        (g_q[i])
        );
    end

    assign mode_sel = g_q[G_MODE];
    assign susp_en  = g_q[G_SEN];

    flc_suspend_ctl u_susp (
        .clk   (clk),
        .rst   (rst),
        .mode  (susp_mode_e'(mode_sel)),
        .en    (susp_en),
        .busy  (erase_busy),
        .irq   (irq_taken),
        .wr    (op.hit_susp),
        .bit_in(op.data[SREQ_BIT]),
        .req   (susp_req)
    );

    always_ff @(posedge clk) begin
        if (rst) stat_q <= SUSP_RST[STAT_BIT];
        else     stat_q <= status_ready;
    end

    flc_read_mux #(
        .ADDR_W   (ADDR_W),
        .MODE_ADDR(MODE_ADDR),
        .SUSP_ADDR(SUSP_ADDR)
    ) u_rd (
        .addr  (addr),
        .mode_q(mode_sel),
        .sen_q (susp_en),
        .sreq_q(susp_req),
        .stat_q(stat_q),
        .rdata (rdata)
    );
endmodule

// File: rtl/flash_ctl_regs_chk.sv
module flash_ctl_regs_chk #(
    parameter int ADDR_W    = 4,
    parameter int SUSP_ADDR = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              rewrite_en,
    input logic              erase_busy,
    input logic              irq_taken,
    input logic              status_ready,
    input logic              mode_sel,
    input logic              susp_en,
    input logic              susp_req,
    input logic              stat_q
);
    p_mode_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_sel) |-> $past(rewrite_en) && $past(wr_en) && $past(!irq_taken));

    p_mode_clear_r3: assert property (@(posedge clk) disable iff (rst)
        !rewrite_en |=> !mode_sel);

    p_sen_by_write_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(susp_en) |-> $past(wr_en) && ($past(32'(addr)) == SUSP_ADDR) && $past(!irq_taken));

    p_req_window_r7: assert property (@(posedge clk) disable iff (rst)
        !(susp_en && erase_busy) |=> !susp_req);

    p_irq_sets_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_sel && susp_en && erase_busy && irq_taken) |=> susp_req);

    p_status_mirror_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stat_q == $past(status_ready)));
endmodule

bind flash_ctl_regs flash_ctl_regs_chk #(
    .ADDR_W   (ADDR_W),
    .SUSP_ADDR(SUSP_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .addr        (addr),
    .rewrite_en  (rewrite_en),
    .erase_busy  (erase_busy),
    .irq_taken   (irq_taken),
    .status_ready(status_ready),
    .mode_sel    (mode_sel),
    .susp_en     (susp_en),
    .susp_req    (susp_req),
    .stat_q      (stat_q)
);

// File: tb/flash_ctl_regs_bench.sv
`timescale 1ns/1ps
module flash_ctl_regs_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rewrite_en = 1'b0;
    logic       erase_busy = 1'b0;
    logic       irq_taken = 1'b0;
    logic       status_ready = 1'b1;
    logic       mode_sel, susp_en, susp_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_ctl_regs u_flash_ctl_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rewrite_en(rewrite_en), .erase_busy(erase_busy),
        .irq_taken(irq_taken), .status_ready(status_ready),
        .mode_sel(mode_sel), .susp_en(susp_en), .susp_req(susp_req)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic irq_pulse();
        @(negedge clk); irq_taken = 1'b1;
        @(negedge clk); irq_taken = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a; #0.5; d = rdata;
    endtask

    initial begin
        logic [7:0] v;
        // R1: reset state, sampled while reset is held
        @(negedge clk); @(negedge clk);
        rd(4'd0, v); chk("R1 mode reg in reset", v, 8'h00);
        rd(4'd1, v); chk("R1 susp reg in reset", v, 8'h40);
        chk("R1 outputs in reset", {5'd0, mode_sel, susp_en, susp_req}, 8'h00);
        do_reset();
        rd(4'd1, v); chk("R1 susp reg after reset", v, 8'h40);

        // R2/R3/R5: sweep of unlock trials for the mode bit
        for (int f = 0; f < 2; f++)
            for (int mid = 0; mid < 3; mid++)
                for (int en = 0; en < 2; en++) begin
                    do_reset();
                    rewrite_en = 1'b1;
                    wr(4'd0, 8'(f));
                    if (mid == 1) wr(4'd5, 8'h00);
                    if (mid == 2) irq_pulse();
                    rewrite_en = 1'(en);
                    wr(4'd0, 8'h01);
                    chk("R2 R3 R5 mode unlock trial", {7'd0, mode_sel},
                        {7'd0, (f == 0) && (mid == 0) && (en == 1)});
                end

        // R3: dropping rewrite_en clears a set mode bit
        do_reset(); rewrite_en = 1'b1;
        wr(4'd0, 8'h00); wr(4'd0, 8'h01);
        chk("R3 mode set before drop", {7'd0, mode_sel}, 8'h01);
        @(negedge clk); rewrite_en = 1'b0;
        @(negedge clk);
        chk("R3 mode cleared by rewrite_en low", {7'd0, mode_sel}, 8'h00);

        // R4/R5: sweep of unlock trials for the suspend enable
        for (int f = 0; f < 2; f++)
            for (int mid = 0; mid < 3; mid++) begin
                do_reset();
                wr(4'd1, 8'(f));
                if (mid == 1) wr(4'd0, 8'h00);
                if (mid == 2) irq_pulse();
                wr(4'd1, 8'h01);
                chk("R4 R5 suspend enable unlock trial", {7'd0, susp_en},
                    {7'd0, (f == 0) && (mid == 0)});
            end

        // R6: writing 0 clears a guarded bit
        wr(4'd1, 8'h00);
        chk("R6 suspend enable cleared", {7'd0, susp_en}, 8'h00);
        do_reset(); rewrite_en = 1'b1;
        wr(4'd0, 8'h00); wr(4'd0, 8'h01); wr(4'd0, 8'h00);
        chk("R6 mode cleared", {7'd0, mode_sel}, 8'h00);

        // R7/R8/R9: suspend request sweep over mode, enable, busy, written value
        for (int m = 0; m < 2; m++)
            for (int en = 0; en < 2; en++)
                for (int b = 0; b < 2; b++)
                    for (int w = 0; w < 2; w++) begin
                        logic g, e1, e2;
                        do_reset();
                        rewrite_en = 1'b1;
                        if (m == 1) begin wr(4'd0, 8'h00); wr(4'd0, 8'h01); end
                        if (en == 1) begin wr(4'd1, 8'h00); wr(4'd1, 8'h01); end
                        erase_busy = 1'(b);
                        g = (en == 1) && (b == 1);
                        wr(4'd1, 8'(en | (w << 1)));
                        e1 = g && (m == 0) && (w == 1);
                        chk("R7 R8 R9 request after write", {7'd0, susp_req}, {7'd0, e1});
                        irq_pulse();
                        e2 = g && ((m == 1) ? 1'b1 : e1);
                        chk("R7 R8 R9 request after irq", {7'd0, susp_req}, {7'd0, e2});
                        wr(4'd1, 8'(en));
                        chk("R8 R9 request after write 0", {7'd0, susp_req}, 8'h00);
                        wr(4'd1, 8'(en | 2));
                        chk("R8 R9 request after write 1", {7'd0, susp_req},
                            {7'd0, g && (m == 0)});
                        @(negedge clk); erase_busy = 1'b0;
                        @(negedge clk);
                        chk("R7 request dropped when erase ends", {7'd0, susp_req}, 8'h00);
                    end

        // R10: status flag mirror, and write has no effect
        do_reset();
        @(negedge clk); status_ready = 1'b0;
        @(negedge clk);
        rd(4'd1, v); chk("R10 status follows input low", v, 8'h00);
        wr(4'd1, 8'h40);
        rd(4'd1, v); chk("R10 status write ignored", v, 8'h00);
        @(negedge clk); status_ready = 1'b1;
        @(negedge clk);
        rd(4'd1, v); chk("R10 status follows input high", v, 8'h40);

        // R11: reserved bits and unused addresses
        do_reset(); rewrite_en = 1'b1;
        wr(4'd0, 8'hFE);
        rd(4'd0, v); chk("R11 mode reg reserved bits", v, 8'h00);
        wr(4'd1, 8'hBC);
        rd(4'd1, v); chk("R11 susp reg reserved bits", v, 8'h40);
        wr(4'd7, 8'hFF);
        rd(4'd7, v); chk("R11 unused address", v, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule